// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

This block collects a set of peripheral interrupt inputs and sends each one to one of several processor cores, and on that core to one of several parent interrupt lines. Each source can be set up as level or edge sensitive, with either polarity. Each source also has an enable bit and a route byte. Software reaches the route bytes, the enable word, the polarity word, the trigger-mode word and one pending-status word per core through a simple 32-bit register bus with byte lanes.

Every raw input first passes through a two-flop synchroniser. After that, the polarity is applied and edges are detected. An edge-sensitive source holds a sticky pending bit. The only way to clear that bit is to clear the source's enable bit (or to switch the source back to level mode). Each core gets a group of output lines, and each line is the OR of every source that is pending and enabled and routed to that core and line.

A bus read returns its data on `bus_rdata` one clock after `bus_rd` is sampled. Writes take effect at the clock edge that samples `bus_wr`.

Top module: `irq_router_top`

## Requirements
- R1: After reset, the controller is in this state:
  - every enable bit, polarity bit and trigger-mode bit is 0;
  - every route byte reads 0x11, which selects core 0 and line 0;
  - `irq_out` is all zero.
- R2: Route bytes are stored four to a word at offsets 0x00 to 0x1C. Lane k of word w is source 4w+k.
  - Bits [7:4] of a route byte select the parent line, with bit 4+p meaning line p.
  - Bits [3:0] select the core, with bit c meaning core c.
  - A write changes only the lanes whose `bus_be` bit is 1.
  - A route byte reads back as it was written.
- R3: Enable register behaviour:
  - A write to 0x28 sets each enable bit whose data bit (in an enabled lane) is 1.
  - A write to 0x2C clears each such enable bit.
  - Data bits of 0 leave the enable bit unchanged.
  - A read of 0x24 returns the enable word.
- R4: The trigger-mode word at 0x34 is read/write with byte lanes. Mode bit 0 selects level mode, in which a source is active while its synchronised input equals the inverse of its polarity bit. Polarity 0 means active-high and 1 means active-low.
- R5: Edge mode (mode bit 1):
  - A rising edge (polarity 0) or a falling edge (polarity 1) sets a sticky pending bit.
  - The bit stays set after the input returns to its former level.
  - Clearing the source's enable bit clears it.
- R6: The polarity word at 0x30 is read/write with byte lanes. Changing it in edge mode while the input is steady does not set the sticky bit.
- R7: The word at 0x40+8n holds the pending sources of core n. Bit i is set when source i is enabled, is pending, and has core bit n set in its route byte.
- R8: `irq_out[4c+p]` is the OR over all sources that are enabled, pending, and have both core bit c and parent bit 4+p set in their route byte.
- R9: Latency from an input change on `src_in` (driven between clock edges):
  - In level mode, the change reaches `irq_out` at the second rising clock edge after it and not at the first.
  - In edge mode, the sticky bit reaches `irq_out` at the third rising clock edge and not at the second.
- R10: These offsets are unmapped for reads and return zero: 0x20, 0x28, 0x2C, 0x38, 0x44 and 0x60. Writes to unmapped or status offsets change no state.
- R11: A disabled source never shows as pending. An edge that arrives while its source is disabled is not remembered once the source is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC (32) | Raw asynchronous interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | NCORE*NLINE (16) | Parent lines, bit 4c+p is line p of core c |

## Verification
The bound properties rely on two assumptions about the inputs:
- the bus never asserts `bus_wr` and `bus_rd` with unknown address or data;
- the enable set and clear checks apply only to writes with all four byte lanes enabled.

The stimulus stays inside these limits:
- Bus strobes are driven only from tasks, always with known values, and are released one cycle later.
- Every source input change is held for at least four cycles, so the synchroniser and the edge detector always see one clean transition.
- Configuration writes and input changes never share a window.

Because of this, the bench's reference model can settle each step before it compares the outputs and status words.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_EN_READ  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EN_CLEAR = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_POLARITY = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_TRIGGER  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_STATUS0  = 8'h40;
    localparam int unsigned       STATUS_STEP  = 8;

    localparam logic [7:0] ROUTE_AT_RESET = 8'h11;

    function automatic logic [DATA_W-1:0] lanes_to_mask(input logic [3:0] be);
        logic [DATA_W-1:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stage1 = d;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.stage2;

endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    input  logic [W-1:0] en,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edge_mode,
    output logic [W-1:0] pend
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] sticky;
    } cap_t;

    cap_t st_d, st_q;
    logic [W-1:0] rise_w, fall_w, hit_w;

    always_comb begin
        rise_w = lvl_in & ~st_q.prev;
        fall_w = ~lvl_in & st_q.prev;
        hit_w  = (rise_w & ~pol) | (fall_w & pol);

        st_d.prev   = lvl_in;
        // sticky bits live only while the source is enabled and in edge mode
        st_d.sticky = (st_q.sticky | hit_w) & en & edge_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = en & ((edge_mode & st_q.sticky) | (~edge_mode & (lvl_in ^ pol)));

endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
    import irq_router_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NCORE = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [3:0]                  be,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NCORE-1:0][NSRC-1:0]  status,
    output logic [DATA_W-1:0]           rdata,
    output logic [NSRC-1:0]             en,
    output logic [NSRC-1:0]             pol,
    output logic [NSRC-1:0]             edge_mode,
    output logic [NSRC-1:0][7:0]        route
);

    localparam int unsigned WORD_A = ADDR_W - 2;

    typedef struct packed {
        logic [NSRC-1:0]      en;
        logic [NSRC-1:0]      pol;
        logic [NSRC-1:0]      edge_mode;
        logic [NSRC-1:0][7:0] route;
        logic [DATA_W-1:0]    rdata;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [NSRC-1:0] wmask_w, wbits_w;

    always_comb begin
        st_d     = st_q;
        wmask_w  = lanes_to_mask(be)[NSRC-1:0];
        wbits_w  = wdata[NSRC-1:0] & wmask_w;

        if (wr) begin
            for (int i = 0; i < NSRC; i++) begin
                if (addr[ADDR_W-1:2] == WORD_A'(i / 4) && be[i % 4]) begin
                    st_d.route[i] = wdata[8*(i % 4) +: 8];
                end
            end
            case (addr)
                OFS_EN_SET:   st_d.en = st_q.en | wbits_w;
                OFS_EN_CLEAR: st_d.en = st_q.en & ~wbits_w;
                OFS_POLARITY: st_d.pol = (st_q.pol & ~wmask_w) | wbits_w;
                OFS_TRIGGER:  st_d.edge_mode = (st_q.edge_mode & ~wmask_w) | wbits_w;
                default: ;
            endcase
        end

        st_d.rdata = '0;
        if (rd) begin
            for (int i = 0; i < NSRC; i++) begin
                if (addr[ADDR_W-1:2] == WORD_A'(i / 4)) begin
                    st_d.rdata[8*(i % 4) +: 8] = st_q.route[i];
                end
            end
            case (addr)
                OFS_EN_READ:  st_d.rdata[NSRC-1:0] = st_q.en;
                OFS_POLARITY: st_d.rdata[NSRC-1:0] = st_q.pol;
                OFS_TRIGGER:  st_d.rdata[NSRC-1:0] = st_q.edge_mode;
                default: ;
            endcase
            for (int n = 0; n < NCORE; n++) begin
                if (addr == ADDR_W'(OFS_STATUS0 + STATUS_STEP * n)) begin
                    st_d.rdata[NSRC-1:0] = status[n];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en        <= '0;
            st_q.pol       <= '0;
            st_q.edge_mode <= '0;
            st_q.route     <= {NSRC{ROUTE_AT_RESET}};
            st_q.rdata     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign en        = st_q.en;
    assign pol       = st_q.pol;
    assign edge_mode = st_q.edge_mode;
    assign route     = st_q.route;

endmodule

// File: rtl/irq_fanout.sv
module irq_fanout #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NCORE = 4,
    parameter int unsigned NLINE = 4
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0][7:0]        route,
    output logic [NCORE-1:0][NSRC-1:0]  status,
    output logic [NCORE*NLINE-1:0]      irq_out
);

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [NSRC-1:0] to_core;
        always_comb begin
            for (int i = 0; i < NSRC; i++) begin
                to_core[i] = pend[i] & route[i][c];
            end
        end
        assign status[c] = to_core;

        for (genvar p = 0; p < NLINE; p++) begin : g_line
            logic [NSRC-1:0] to_line;
            always_comb begin
                for (int i = 0; i < NSRC; i++) begin
                    to_line[i] = to_core[i] & route[i][NCORE + p];
                end
            end
            assign irq_out[c*NLINE + p] = |to_line;
        end
    end

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
    import irq_router_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NCORE = 4,
    parameter int unsigned NLINE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         src_in,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [7:0]              bus_addr,
    input  logic [3:0]              bus_be,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NCORE*NLINE-1:0]  irq_out
);

    logic [NSRC-1:0]            sync_w;
    logic [NSRC-1:0]            en_w, pol_w, mode_w, pend_w;
    logic [NSRC-1:0][7:0]       route_w;
    logic [NCORE-1:0][NSRC-1:0] status_w;

    irq_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_in),
        .q     (sync_w)
    );

    irq_cfg #(.NSRC(NSRC), .NCORE(NCORE)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .status    (status_w),
        .rdata     (bus_rdata),
        .en        (en_w),
        .pol       (pol_w),
        .edge_mode (mode_w),
        .route     (route_w)
    );

    irq_capture #(.W(NSRC)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (sync_w),
        .en        (en_w),
        .pol       (pol_w),
        .edge_mode (mode_w),
        .pend      (pend_w)
    );

    irq_fanout #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_fan (
        .pend    (pend_w),
        .route   (route_w),
        .status  (status_w),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_addr,
    input logic [3:0]       bus_be,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [OUT_W-1:0] irq_out,
    input logic [NSRC-1:0]  en
);

    // R11: nothing reaches a parent line while every source is disabled
    a_r11_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (irq_out == '0));

    // R3: full-lane write-1-to-set takes effect on the next cycle
    a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h28 && bus_be == 4'hF)
        |=> ((en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R3: full-lane write-1-to-clear takes effect on the next cycle
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h2C && bus_be == 4'hF)
        |=> ((en & $past(bus_wdata[NSRC-1:0])) == '0));

    // R3: enable readback matches the enable state at the read
    a_r3_en_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h24 && !bus_wr)
        |=> (bus_rdata[NSRC-1:0] == $past(en)));

    // R10: unmapped read offsets return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 8'h20 || bus_addr == 8'h28 || bus_addr == 8'h2C
                    || bus_addr == 8'h38 || bus_addr == 8'h44 || bus_addr == 8'h60))
        |=> (bus_rdata == '0));

    // R10: a write to a status offset leaves enables unchanged
    a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h40) |=> $stable(en));

endmodule

bind irq_router_top irq_router_chk #(.NSRC(NSRC), .OUT_W(NCORE*NLINE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en        (en_w)
);

// File: tb/irq_router_top_tb.sv
`timescale 1ns/1ps
module irq_router_top_tb;

    localparam int NSRC = 32;
    localparam int NCORE = 4;
    localparam int NLINE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // model state
    logic [7:0]  m_route [NSRC];
    logic [31:0] m_en, m_pol, m_mode, m_sticky, m_in;

    irq_router_top #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_bits(input logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = be[k] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic logic [31:0] exp_pend();
        return m_en & ((m_mode & m_sticky) | (~m_mode & (m_in ^ m_pol)));
    endfunction

    function automatic logic [31:0] exp_status(input int c);
        logic [31:0] p = exp_pend();
        logic [31:0] s;
        for (int i = 0; i < NSRC; i++) s[i] = p[i] & m_route[i][c];
        return s;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [31:0] p = exp_pend();
        logic [15:0] o = '0;
        for (int c = 0; c < NCORE; c++)
            for (int l = 0; l < NLINE; l++)
                for (int i = 0; i < NSRC; i++)
                    if (p[i] && m_route[i][c] && m_route[i][4+l]) o[c*NLINE+l] = 1'b1;
        return o;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic mdl_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] lm = lane_bits(be);
        if (a < 8'h20) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) m_route[int'(a[7:2])*4 + k] = d[8*k +: 8];
        end else begin
            case (a)
                8'h28: m_en = m_en | (d & lm);
                8'h2C: m_en = m_en & ~(d & lm);
                8'h30: m_pol = (m_pol & ~lm) | (d & lm);
                8'h34: m_mode = (m_mode & ~lm) | (d & lm);
                default: ;
            endcase
        end
        m_sticky = m_sticky & m_en & m_mode;
        bus_write(a, be, d);
        wait_cyc(4);
    endtask

    task automatic drive_src(input logic [31:0] v);
        logic [31:0] hit;
        hit = ((v & ~m_in) & ~m_pol) | ((~v & m_in) & m_pol);
        m_sticky = (m_sticky | hit) & m_en & m_mode;
        m_in = v;
        @(negedge clk);
        src_in = v;
        wait_cyc(4);
    endtask

    task automatic check_outputs(input string req, input bit with_status);
        logic [31:0] rd;
        chk(req, {16'h0, irq_out}, {16'h0, exp_irq()});
        if (with_status) begin
            for (int c = 0; c < NCORE; c++) begin
                bus_read(8'(8'h40 + 8*c), rd);
                chk("R7 status", rd, exp_status(c));
            end
        end
    endtask

    task automatic check_config(input string req);
        logic [31:0] rd, e;
        for (int w = 0; w < 8; w++) begin
            bus_read(8'(4*w), rd);
            e = {m_route[4*w+3], m_route[4*w+2], m_route[4*w+1], m_route[4*w]};
            chk(req, rd, e);
        end
        bus_read(8'h24, rd); chk(req, rd, m_en);
        bus_read(8'h30, rd); chk(req, rd, m_pol);
        bus_read(8'h34, rd); chk(req, rd, m_mode);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int seed_dummy;
        seed_dummy = $urandom(32'd7321);
        for (int i = 0; i < NSRC; i++) m_route[i] = 8'h11;
        m_en = '0; m_pol = '0; m_mode = '0; m_sticky = '0; m_in = '0;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        chk("R1 irq_out", {16'h0, irq_out}, 32'h0);
        check_config("R1 reset config");

        // R2 partial lane route write and readback
        mdl_write(8'h04, 4'b0101, 32'hAABB2482);
        check_config("R2 route lanes");

        // R9 level latency, source 0, route back to core0 line0
        mdl_write(8'h04, 4'hF, 32'h11111111);
        mdl_write(8'h28, 4'hF, 32'h1);
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk); chk("R9 level first edge", {31'h0, irq_out[0]}, 32'h0);
        @(negedge clk); chk("R9 level second edge", {31'h0, irq_out[0]}, 32'h1);
        @(negedge clk); src_in[0] = 1'b0; wait_cyc(4);
        chk("R4 level drop", {31'h0, irq_out[0]}, 32'h0);

        // R9 edge latency + R5 stickiness
        mdl_write(8'h34, 4'hF, 32'h1);
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R9 edge second edge", {31'h0, irq_out[0]}, 32'h0);
        @(negedge clk); chk("R9 edge third edge", {31'h0, irq_out[0]}, 32'h1);
        m_in[0] = 1'b1; m_sticky[0] = 1'b1;
        drive_src(32'h0);
        chk("R5 sticky after return", {31'h0, irq_out[0]}, 32'h1);
        mdl_write(8'h2C, 4'hF, 32'h1);
        chk("R5 cleared by disable", {31'h0, irq_out[0]}, 32'h0);

        // R11 edge while disabled is forgotten
        drive_src(32'h1);
        mdl_write(8'h28, 4'hF, 32'h1);
        chk("R11 no stale edge", {31'h0, irq_out[0]}, 32'h0);

        // R6 polarity flip in edge mode with steady input does not capture
        mdl_write(8'h30, 4'hF, 32'h1);
        chk("R6 pol change no capture", {31'h0, irq_out[0]}, 32'h0);
        drive_src(32'h0);
        chk("R5 falling edge capture", {31'h0, irq_out[0]}, 32'h1);
        mdl_write(8'h2C, 4'hF, 32'hFFFFFFFF);

        // R10 unmapped reads and inert writes
        bus_read(8'h20, rd); chk("R10 read 0x20", rd, 32'h0);
        bus_read(8'h28, rd); chk("R10 read 0x28", rd, 32'h0);
        bus_read(8'h2C, rd); chk("R10 read 0x2C", rd, 32'h0);
        bus_read(8'h38, rd); chk("R10 read 0x38", rd, 32'h0);
        bus_read(8'h44, rd); chk("R10 read 0x44", rd, 32'h0);
        bus_read(8'h60, rd); chk("R10 read 0x60", rd, 32'h0);
        mdl_write(8'h20, 4'hF, 32'hFFFFFFFF);
        mdl_write(8'h40, 4'hF, 32'hFFFFFFFF);
        mdl_write(8'h3C, 4'hF, 32'hFFFFFFFF);
        check_config("R10 inert writes");

        // randomised mix: R3 R4 R5 R7 R8
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 9));
            logic [31:0] r = $urandom;
            logic [3:0]  be = (($urandom_range(0, 3)) == 0) ? 4'($urandom) : 4'hF;
            case (op)
                0, 1: mdl_write(8'h28, be, r);
                2:    mdl_write(8'h2C, be, r & $urandom);
                3:    mdl_write(8'h30, be, r);
                4:    mdl_write(8'h34, be, r);
                5: begin
                    logic [7:0] rb;
                    if ($urandom_range(0, 3) == 0) rb = 8'($urandom);
                    else rb = {4'b0001 << $urandom_range(0, 3), 4'b0001 << $urandom_range(0, 3)};
                    mdl_write(8'(4 * $urandom_range(0, 7)), 4'b0001 << $urandom_range(0, 3),
                              {rb, rb, rb, rb});
                end
                default: drive_src(m_in ^ (r & $urandom));
            endcase
            check_outputs("R8 irq_out", (it % 8) == 0);
        end
        check_config("R3 R4 R6 final config");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule